// File: doc/BRIEF.md
# Clock Reference Selection Front End

This block conditions the timing references that feed a digital PLL. It takes two external reference inputs and one internally derived 8 kHz frame reference and brings each into the system clock domain through a synchronizer. It then builds a primary reference from either the external primary input or the internal frame reference. A second select makes either the primary or the external secondary reference the preferred one, and the other becomes the backup. Each external input has its own polarity inversion. The block emits a single-cycle event on every rising edge of the conditioned preferred and backup references.

All configuration inputs are captured into a register that reset clears. The register also holds the nominal rate code of each external input, which goes out alongside the preferred and backup assignment for a downstream monitor. The block flags the one illegal rate setting. It decodes the PLL operating mode from two control bits and, in bypass mode, steers the raw input clock to the clock output in place of the PLL clock.

Top module: `ref_select_front`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `mode_o` is master (2'b00), both edge outputs are 0 and `cfg_err_o` is 0, whatever the configuration inputs hold.
- R2: Mode encoding on `mode_o` is 2'b00 master, 2'b01 freerun and 2'b10 bypass. `ctl_byp_i`=1 gives bypass whatever `mode_sel_i` holds. `ctl_byp_i`=0 with `mode_sel_i`=1 gives freerun, and both at 0 give master. A change shows one clock after it is applied.
- R3: `clk_sel_o` follows `ref_clk_i` combinationally when the decoded mode is bypass, and follows `pll_clk_i` in master and freerun.
- R4: `pri_src_i`=0 takes the primary reference from `ext_pri_i`, and `pri_src_i`=1 takes it from `int_frame_i`. Edges on the unselected source produce no event.
- R5: `pref_sec_i`=0 makes the primary reference preferred and the secondary backup. `pref_sec_i`=1 swaps them. `pref_freq_o` and `bkp_freq_o` carry the 2-bit rate codes of the reference in each role (00 8 kHz, 01 1.544 MHz, 10 2.048 MHz).
- R6: `pri_inv_i` inverts `ext_pri_i` and `sec_inv_i` inverts `ext_sec_i` before edge detection, so that a falling input gives the event. The internal frame reference is never inverted.
- R7: An input rise applied before clock edge k raises the matching edge output after edge k+1 for exactly one clock.
- R8: `cfg_err_o` is 1 one clock after `pri_src_i`=1 is applied together with a nonzero `pri_freq_i`, and is 0 otherwise.
- R9: Changing `pref_sec_i` takes effect on the next clock. The switch itself creates no edge event on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_pri_i | input | 1 | External primary reference |
| ext_sec_i | input | 1 | External secondary reference |
| int_frame_i | input | 1 | Internal 8 kHz frame reference |
| pri_src_i | input | 1 | Primary source: 0 external, 1 internal |
| pref_sec_i | input | 1 | Preferred: 0 primary, 1 secondary |
| pri_inv_i | input | 1 | Invert external primary |
| sec_inv_i | input | 1 | Invert external secondary |
| pri_freq_i | input | 2 | Rate code of primary input |
| sec_freq_i | input | 2 | Rate code of secondary input |
| ctl_byp_i | input | 1 | Control bit forcing bypass |
| mode_sel_i | input | 1 | Mode bit: freerun when set |
| pll_clk_i | input | 1 | PLL output clock |
| ref_clk_i | input | 1 | Raw input clock for bypass |
| pref_edge_o | output | 1 | Rising-edge event of preferred reference |
| bkp_edge_o | output | 1 | Rising-edge event of backup reference |
| pref_freq_o | output | 2 | Rate code of preferred reference |
| bkp_freq_o | output | 2 | Rate code of backup reference |
| mode_o | output | 2 | Decoded PLL mode |
| cfg_err_o | output | 1 | Internal source with nonzero rate code |
| clk_sel_o | output | 1 | PLL clock or bypassed input clock |

## Verification
The assertions check on every cycle that each edge event lasts a single clock and that the preferred/backup swap neither adds nor drops events. They also check that the bypass bit and the illegal rate setting show on the outputs one clock after they are applied, that the clock mux follows the decoded mode, and that reset release leaves master mode. Only the bench scenarios can show that the right source reaches the right role, the two-clock edge latency, the inversion of each external input but not the internal one, and the absence of events across a preferred switch with a reference held high.

// File: rtl/ref_fe_pkg.sv
package ref_fe_pkg;
  typedef enum logic [1:0] {
    MODE_MASTER  = 2'b00,
    MODE_FREERUN = 2'b01,
    MODE_BYPASS  = 2'b10
  } pll_mode_e;

  localparam int FREQ_W = 2;
  localparam logic [FREQ_W-1:0] FREQ_8K = '0;
endpackage

// File: rtl/ref_sync.sv
// Multi-stage synchronizer; STAGES must be at least 2.
module ref_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ref_edge_det.sv
module ref_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R7: each event lasts exactly one clock
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ref_mode_dec.sv
module ref_mode_dec
  import ref_fe_pkg::*;
(
  input  logic      ctl_byp_i,
  input  logic      mode_sel_i,
  input  logic      pll_clk_i,
  input  logic      ref_clk_i,
  output pll_mode_e mode_o,
  output logic      clk_sel_o
);
  always_comb begin
    if (ctl_byp_i)       mode_o = MODE_BYPASS;
    else if (mode_sel_i) mode_o = MODE_FREERUN;
    else                 mode_o = MODE_MASTER;
  end

  assign clk_sel_o = (mode_o == MODE_BYPASS) ? ref_clk_i : pll_clk_i;
endmodule

// File: rtl/ref_select_front.sv
module ref_select_front
  import ref_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pri_i,
  input  logic              ext_sec_i,
  input  logic              int_frame_i,
  input  logic              pri_src_i,
  input  logic              pref_sec_i,
  input  logic              pri_inv_i,
  input  logic              sec_inv_i,
  input  logic [FREQ_W-1:0] pri_freq_i,
  input  logic [FREQ_W-1:0] sec_freq_i,
  input  logic              ctl_byp_i,
  input  logic              mode_sel_i,
  input  logic              pll_clk_i,
  input  logic              ref_clk_i,
  output logic              pref_edge_o,
  output logic              bkp_edge_o,
  output logic [FREQ_W-1:0] pref_freq_o,
  output logic [FREQ_W-1:0] bkp_freq_o,
  output logic [1:0]        mode_o,
  output logic              cfg_err_o,
  output logic              clk_sel_o
);
  localparam int N_IN  = 3;
  localparam int N_REF = 2;
  localparam int I_PRI = 0;
  localparam int I_SEC = 1;
  localparam int I_INT = 2;

  typedef struct packed {
    logic              pri_src;
    logic              pref_sec;
    logic              pri_inv;
    logic              sec_inv;
    logic              ctl_byp;
    logic              mode_sel;
    logic [FREQ_W-1:0] pri_freq;
    logic [FREQ_W-1:0] sec_freq;
  } cfg_t;

  cfg_t cfg_q;

  // reset clears every control bit -> master mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else cfg_q <= '{pri_src: pri_src_i, pref_sec: pref_sec_i, pri_inv: pri_inv_i,
                    sec_inv: sec_inv_i, ctl_byp: ctl_byp_i, mode_sel: mode_sel_i,
                    pri_freq: pri_freq_i, sec_freq: sec_freq_i};
  end

  logic [N_IN-1:0]  sync_lvl;
  logic [N_REF-1:0] ref_lvl;
  logic [N_REF-1:0] ref_rise;

  ref_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_IN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({int_frame_i, ext_sec_i, ext_pri_i}),
    .q_o   (sync_lvl)
  );

  // internal frame reference bypasses the inversion
  assign ref_lvl[0] = cfg_q.pri_src ? sync_lvl[I_INT]
                                    : (sync_lvl[I_PRI] ^ cfg_q.pri_inv);
  assign ref_lvl[1] = sync_lvl[I_SEC] ^ cfg_q.sec_inv;

  ref_edge_det #(.WIDTH(N_REF)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ref_lvl),
    .rise_o(ref_rise)
  );

  // swap after edge detection: a role change cannot fabricate an edge
  assign pref_edge_o = cfg_q.pref_sec ? ref_rise[1] : ref_rise[0];
  assign bkp_edge_o  = cfg_q.pref_sec ? ref_rise[0] : ref_rise[1];
  assign pref_freq_o = cfg_q.pref_sec ? cfg_q.sec_freq : cfg_q.pri_freq;
  assign bkp_freq_o  = cfg_q.pref_sec ? cfg_q.pri_freq : cfg_q.sec_freq;

  assign cfg_err_o = cfg_q.pri_src && (cfg_q.pri_freq != FREQ_8K);

  pll_mode_e mode_w;

  ref_mode_dec u_mode (
    .ctl_byp_i (cfg_q.ctl_byp),
    .mode_sel_i(cfg_q.mode_sel),
    .pll_clk_i (pll_clk_i),
    .ref_clk_i (ref_clk_i),
    .mode_o    (mode_w),
    .clk_sel_o (clk_sel_o)
  );

  assign mode_o = mode_w;

  p_reset_master_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mode_o == MODE_MASTER && !pref_edge_o && !bkp_edge_o && !cfg_err_o));

  p_bypass_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_byp_i |=> (mode_o == MODE_BYPASS));

  p_clk_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_BYPASS) |-> (clk_sel_o == ref_clk_i));

  p_cfg_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_src_i && pri_freq_i != FREQ_8K) |=> cfg_err_o);

  p_swap_keeps_events_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pref_edge_o, bkp_edge_o}) == $countones(ref_rise));
endmodule

// File: tb/ref_select_front_tb_top.sv
`timescale 1ns/1ps
module ref_select_front_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_pri_i = 0, ext_sec_i = 0, int_frame_i = 0;
  logic pri_src_i = 0, pref_sec_i = 0, pri_inv_i = 0, sec_inv_i = 0;
  logic [1:0] pri_freq_i = 0, sec_freq_i = 0;
  logic ctl_byp_i = 0, mode_sel_i = 0, pll_clk_i = 0, ref_clk_i = 0;
  logic pref_edge_o, bkp_edge_o, cfg_err_o, clk_sel_o;
  logic [1:0] pref_freq_o, bkp_freq_o, mode_o;
  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  ref_select_front dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (6) step();
  endtask

  // called right after an input change at a falling edge (R7 latency)
  task automatic probe(input string req, input int ep, input int eb);
    step();
    chk({req, " R7 early pref"}, pref_edge_o, 0);
    chk({req, " R7 early bkp"}, bkp_edge_o, 0);
    step();
    chk({req, " pref"}, pref_edge_o, ep);
    chk({req, " bkp"}, bkp_edge_o, eb);
    step();
    chk({req, " R7 width pref"}, pref_edge_o, 0);
    chk({req, " R7 width bkp"}, bkp_edge_o, 0);
  endtask

  task automatic t_reset();
    ctl_byp_i = 1; pri_src_i = 1; pri_freq_i = 2'b11;
    repeat (3) step();
    chk("R1 mode in reset", mode_o, 0);
    chk("R1 err in reset", cfg_err_o, 0);
    chk("R1 edges in reset", {pref_edge_o, bkp_edge_o}, 0);
    ctl_byp_i = 0; pri_src_i = 0; pri_freq_i = 0;
    rst_ni = 1;
    step();
    chk("R1 mode after release", mode_o, 0);
    settle();
  endtask

  task automatic t_mode();
    mode_sel_i = 1; step(); chk("R2 freerun", mode_o, 1);
    ctl_byp_i = 1;  step(); chk("R2 bypass mb=1", mode_o, 2);
    mode_sel_i = 0; step(); chk("R2 bypass mb=0", mode_o, 2);
    ctl_byp_i = 0;  step(); chk("R2 master", mode_o, 0);
  endtask

  task automatic t_clk_route();
    pll_clk_i = 1; ref_clk_i = 0; #1;
    chk("R3 master pll", clk_sel_o, 1);
    ctl_byp_i = 1; step();
    pll_clk_i = 0; ref_clk_i = 1; #1;
    chk("R3 bypass ref hi", clk_sel_o, 1);
    ref_clk_i = 0; pll_clk_i = 1; #1;
    chk("R3 bypass ref lo", clk_sel_o, 0);
    ctl_byp_i = 0; mode_sel_i = 1; step();
    chk("R3 freerun pll", clk_sel_o, 1);
    mode_sel_i = 0; pll_clk_i = 0; step();
  endtask

  task automatic t_primary_src();
    pri_src_i = 0; pref_sec_i = 0; settle();
    int_frame_i = 1; probe("R4 int unselected", 0, 0);
    ext_pri_i = 1;   probe("R4 ext selected", 1, 0);
    ext_pri_i = 0; int_frame_i = 0; settle();
    pri_src_i = 1; settle();
    ext_pri_i = 1;   probe("R4 ext unselected", 0, 0);
    int_frame_i = 1; probe("R4 int selected", 1, 0);
    ext_pri_i = 0; int_frame_i = 0; pri_src_i = 0; settle();
  endtask

  task automatic t_roles();
    pref_sec_i = 1; pri_freq_i = 2'b01; sec_freq_i = 2'b10; step();
    chk("R5 pref freq swapped", pref_freq_o, 2);
    chk("R5 bkp freq swapped", bkp_freq_o, 1);
    settle();
    ext_sec_i = 1; probe("R5 sec preferred", 1, 0);
    ext_pri_i = 1; probe("R5 pri backup", 0, 1);
    ext_sec_i = 0; ext_pri_i = 0; settle();
    pref_sec_i = 0; step();
    chk("R5 pref freq direct", pref_freq_o, 1);
    chk("R5 bkp freq direct", bkp_freq_o, 2);
    settle();
    ext_sec_i = 1; probe("R5 sec backup", 0, 1);
    ext_sec_i = 0; pri_freq_i = 0; sec_freq_i = 0; settle();
  endtask

  task automatic t_invert();
    pri_inv_i = 1; settle();
    ext_pri_i = 1; probe("R6 pri inv rise", 0, 0);
    ext_pri_i = 0; probe("R6 pri inv fall", 1, 0);
    sec_inv_i = 1; settle();
    ext_sec_i = 1; probe("R6 sec inv rise", 0, 0);
    ext_sec_i = 0; probe("R6 sec inv fall", 0, 1);
    pri_src_i = 1; settle();
    int_frame_i = 1; probe("R6 int not inverted", 1, 0);
    int_frame_i = 0; pri_src_i = 0; pri_inv_i = 0; sec_inv_i = 0; settle();
  endtask

  task automatic t_cfg_err();
    pri_src_i = 1; pri_freq_i = 2'b00; step();
    chk("R8 internal 8k ok", cfg_err_o, 0);
    pri_freq_i = 2'b01;
    chk("R8 not yet", cfg_err_o, 0);
    step();
    chk("R8 internal bad code", cfg_err_o, 1);
    pri_freq_i = 2'b10; step();
    chk("R8 internal code 10", cfg_err_o, 1);
    pri_src_i = 0; step();
    chk("R8 external any code", cfg_err_o, 0);
    pri_freq_i = 0; settle();
  endtask

  task automatic t_switch();
    pref_sec_i = 0; ext_pri_i = 1; settle();
    pref_sec_i = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 no spur pref", pref_edge_o, 0);
      chk("R9 no spur bkp", bkp_edge_o, 0);
    end
    pref_sec_i = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 no spur back pref", pref_edge_o, 0);
      chk("R9 no spur back bkp", bkp_edge_o, 0);
    end
    pref_sec_i = 1; ext_sec_i = 1;
    probe("R9 new role active", 1, 0);
    ext_pri_i = 0; ext_sec_i = 0; pref_sec_i = 0; settle();
  endtask

  initial begin
    t_reset();
    t_mode();
    t_clk_route();
    t_primary_src();
    t_roles();
    t_invert();
    t_cfg_err();
    t_switch();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule